// File: doc/BRIEF.md
# Clear-to-Send Change Detector with Masked Interrupt

This block watches the active-low clear-to-send pin of a serial port. The pin passes through a synchroniser and a debounce filter, and the filtered level is shown in a read-only port-change register. A change flag in the same register is set whenever the filtered level moves and stays at the new value for a full debounce window. The flag is also set once when, shortly after reset, the pin is first sampled and found asserted. Any read of the port-change register clears the flag.

A write-only auxiliary register holds the input-enable bit. When that bit is set, each change event also sets the change bit of an interrupt status vector. Other interrupt causes, such as transmit-ready and receive-ready, come in as generic status inputs. The status vector and the interrupt mask share one bus address: a read of that address returns the status and a write to it sets the mask. The interrupt line is the registered OR of the status bits whose mask bits are set.

Top module: `cts_cos_intr`

## Requirements
- R1: A read of address 1 (port-change register) returns the change flag in bit 4 and the filtered pin level in bit 0. All other bits read as zero. The level bit is 0 when the pin is low (asserted) and 1 when it is high.
- R2: After reset is released, the pin value present at the first clock edge is loaded into the level bit. This happens STARTUP_CYCLES+1 edges after release. If that value is low, the change flag is set. Before that point, no pin activity sets the flag.
- R3: A change of the filtered level needs the pin to hold the opposite value for DEBOUNCE_CYCLES consecutive clock edges. Shorter pulses leave both the level bit and the change flag unchanged.
- R4: A read of address 1 clears the change flag and the change status bit at the clock edge that ends the read. The data returned by that read shows the values from before the clear.
- R5: When a read of address 1 and a new qualified change event fall on the same edge, the new event wins and the change flag stays set.
- R6: Bit 0 of the write-only auxiliary register (address 0) enables the change status bit. While that bit is 0, change events set only the flag and never the status bit. Address 0 reads as zero.
- R7: Address 2 is shared. A read returns the status vector, with the change status bit in bit 0 and generic input i in bit i+1; the other bits are zero. A write to address 2 loads the mask register.
- R8: The interrupt output is the OR of status bits whose mask bit is 1. It is registered, so it reflects the status and mask of the previous clock cycle. A status bit whose mask bit is 0 has no effect.
- R9: After reset the interrupt is low, the mask and the enable bit are 0, the status reads zero, and addresses 0 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctsN | input | 1 | Clear-to-send pin, active low, asynchronous |
| genStatus | input | NUM_GEN | Generic interrupt causes, level-sensitive |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from the current state |
| irq | output | 1 | Interrupt request |

## Verification
Count the edges from the first edge that captures a new pin value. A sustained pin change moves the level bit, the change flag and the change status bit on edge DEBOUNCE_CYCLES+2, and the interrupt follows one edge later. The bench drives the pin at a falling edge and samples the interrupt at falling edges on both sides of that boundary. A mask or generic-input change appears on the interrupt after one edge, so the mask sweep waits two edges before it compares. Read data is combinational and is sampled before the edge that ends the read. A separate read then confirms the clear, or, for the collision case, that the flag survived. The bench times that collision read so that its ending edge is the qualifying edge of a transition.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int REG_W       = 8;
  localparam int ADDR_W      = 2;
  localparam int SYNC_STAGES = 2;

  localparam logic [ADDR_W-1:0] ADDR_AUX  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PORT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  localparam int PORT_FLAG_BIT  = 4;
  localparam int PORT_LEVEL_BIT = 0;
  localparam int STAT_COS_BIT   = 0;

  typedef struct packed {
    logic wrAux;
    logic wrMask;
    logic rdPort;
    logic startSample;
  } ctsStrobe_t;
endpackage

// File: rtl/cts_ctrl.sv
module cts_ctrl
  import cts_pkg::*;
#(
  parameter int STARTUP_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output ctsStrobe_t        strb,
  output logic              iec,
  output logic [REG_W-1:0]  mask
);
  localparam int FIRE_AT = STARTUP_CYCLES + SYNC_STAGES - 2;
  localparam int CNT_W   = $clog2(FIRE_AT + 2);

  logic [CNT_W-1:0] startCnt;
  logic             started;

  always_comb begin
    strb             = '0;
    strb.wrAux       = busSel && busWr && (busAddr == ADDR_AUX);
    strb.wrMask      = busSel && busWr && (busAddr == ADDR_STAT);
    strb.rdPort      = busSel && !busWr && (busAddr == ADDR_PORT);
    strb.startSample = !started && (startCnt == CNT_W'(FIRE_AT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCnt <= '0;
      started  <= 1'b0;
    end else if (!started) begin
      if (strb.startSample) started  <= 1'b1;
      else                  startCnt <= startCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iec  <= 1'b0;
      mask <= '0;
    end else begin
      if (strb.wrAux)  iec  <= busWdata[0];
      if (strb.wrMask) mask <= busWdata;
    end
  end
endmodule

// File: rtl/cts_filter.sv
module cts_filter
  import cts_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic ctsN,
  input  logic startSample,
  output logic level,
  output logic qualEvt
);
  localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic [CNT_W-1:0]       stableCnt;
  logic                   armed;
  logic                   differs;
  logic                   windowDone;

  generate
    genvar s;
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b1;
        else if (s == 0) syncQ[s] <= ctsN;
        else syncQ[s] <= syncQ[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign syncOut    = syncQ[SYNC_STAGES-1];
  assign differs    = armed && (syncOut != level);
  assign windowDone = (stableCnt == CNT_W'(DEBOUNCE_CYCLES - 1));
  assign qualEvt    = (startSample && !syncOut) || (differs && windowDone);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level     <= 1'b0;
      armed     <= 1'b0;
      stableCnt <= '0;
    end else if (startSample) begin
      armed     <= 1'b1;
      level     <= syncOut;
      stableCnt <= '0;
    end else if (differs) begin
      if (windowDone) begin
        level     <= syncOut;
        stableCnt <= '0;
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end else begin
      stableCnt <= '0;
    end
  end
endmodule

// File: rtl/cts_flags.sv
module cts_flags
  import cts_pkg::*;
#(
  parameter int NUM_GEN = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdPort,
  input  logic               qualEvt,
  input  logic               iec,
  input  logic [REG_W-1:0]   mask,
  input  logic [NUM_GEN-1:0] genStatus,
  output logic               cosFlag,
  output logic               cosStat,
  output logic [REG_W-1:0]   statusVec,
  output logic               irq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cosFlag <= 1'b0;
      cosStat <= 1'b0;
    end else begin
      if (qualEvt)     cosFlag <= 1'b1;
      else if (rdPort) cosFlag <= 1'b0;
      if (qualEvt && iec) cosStat <= 1'b1;
      else if (rdPort)    cosStat <= 1'b0;
    end
  end

  always_comb begin
    statusVec                 = '0;
    statusVec[STAT_COS_BIT]   = cosStat;
    statusVec[NUM_GEN:1]      = genStatus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |(statusVec & mask);
  end
endmodule

// File: rtl/cts_cos_intr.sv
module cts_cos_intr
  import cts_pkg::*;
#(
  parameter int NUM_GEN         = 2,
  parameter int DEBOUNCE_CYCLES = 32,
  parameter int STARTUP_CYCLES  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctsN,
  input  logic [NUM_GEN-1:0] genStatus,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [1:0]         busAddr,
  input  logic [7:0]         busWdata,
  output logic [7:0]         busRdata,
  output logic               irq
);
  ctsStrobe_t       strb;
  logic             iec;
  logic [REG_W-1:0] mask;
  logic             level;
  logic             qualEvt;
  logic             cosFlag;
  logic             cosStat;
  logic [REG_W-1:0] statusVec;

  cts_ctrl #(.STARTUP_CYCLES(STARTUP_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata),
    .strb(strb), .iec(iec), .mask(mask)
  );

  cts_filter #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) uFilter (
    .clk(clk), .rstN(rstN), .ctsN(ctsN), .startSample(strb.startSample),
    .level(level), .qualEvt(qualEvt)
  );

  cts_flags #(.NUM_GEN(NUM_GEN)) uFlags (
    .clk(clk), .rstN(rstN), .rdPort(strb.rdPort), .qualEvt(qualEvt),
    .iec(iec), .mask(mask), .genStatus(genStatus),
    .cosFlag(cosFlag), .cosStat(cosStat), .statusVec(statusVec), .irq(irq)
  );

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_PORT: begin
        busRdata[PORT_FLAG_BIT]  = cosFlag;
        busRdata[PORT_LEVEL_BIT] = level;
      end
      ADDR_STAT: busRdata = statusVec;
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/cts_checker.sv
module cts_checker (
  input logic       clk,
  input logic       rstN,
  input logic       qualEvt,
  input logic       startSample,
  input logic       rdPort,
  input logic       level,
  input logic       cosFlag,
  input logic       cosStat,
  input logic       iec,
  input logic [7:0] mask,
  input logic       irq
);
  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mask == 8'd0) |=> !irq); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdPort && !qualEvt) |=> (!cosFlag && !cosStat)); // R4
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    qualEvt |=> cosFlag); // R5
  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (!iec && !cosStat) |=> !cosStat); // R6
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!qualEvt && !startSample) |=> $stable(level)); // R3
  AST_STAT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    cosStat |-> cosFlag); // R4
endmodule

bind cts_cos_intr cts_checker uChk (
  .clk(clk), .rstN(rstN), .qualEvt(qualEvt), .startSample(strb.startSample),
  .rdPort(strb.rdPort), .level(level), .cosFlag(cosFlag), .cosStat(cosStat),
  .iec(iec), .mask(mask), .irq(irq)
);

// File: tb/tb_cts_cos_intr.sv
module tb_cts_cos_intr;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 2;
  localparam int DB = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ctsN = 1'b1;
  logic [NG-1:0] genStatus = '0;
  logic          busSel = 1'b0;
  logic          busWr = 1'b0;
  logic [1:0]    busAddr = '0;
  logic [7:0]    busWdata = '0;
  logic [7:0]    busRdata;
  logic          irq;
  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cts_cos_intr #(.NUM_GEN(NG), .DEBOUNCE_CYCLES(DB), .STARTUP_CYCLES(2)) dut (
    .clk(clk), .rstN(rstN), .ctsN(ctsN), .genStatus(genStatus),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic doReset(input logic pin);
    @(negedge clk);
    rstN = 1'b0; ctsN = pin;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] rd;
    // R9 and R2: reset with pin deasserted
    doReset(1'b1);
    chk("R9 irq after reset", {7'd0, irq}, 8'h00);
    busRead(2'd0, rd); chk("R9 aux reads zero", rd, 8'h00);
    busRead(2'd3, rd); chk("R9 addr3 reads zero", rd, 8'h00);
    busRead(2'd2, rd); chk("R9 status zero", rd, 8'h00);
    busRead(2'd1, rd); chk("R2 startup high level", rd, 8'h01);

    // R2, R6: reset with pin asserted; enable is zero after reset
    doReset(1'b0);
    busRead(2'd2, rd); chk("R6 startup no status", rd, 8'h00);
    busRead(2'd1, rd); chk("R2 startup asserted flag", rd, 8'h10);
    busRead(2'd1, rd); chk("R4 flag cleared by read", rd, 8'h00);

    // R3 debounce sweep over pulse length, enable on
    busWrite(2'd0, 8'h01);
    for (int len = 1; len <= DB + 2; len++) begin
      @(negedge clk); ctsN = 1'b1;
      repeat (len) @(posedge clk);
      @(negedge clk); ctsN = 1'b0;
      repeat (2*DB + 6) @(negedge clk);
      busRead(2'd2, rd);
      chk("R3 R6 sweep status", rd, (len >= DB) ? 8'h01 : 8'h00);
      busRead(2'd1, rd);
      chk("R3 R1 sweep port", rd, (len >= DB) ? 8'h10 : 8'h00);
    end

    // R8 exact irq timing and R3 edge of update
    busWrite(2'd2, 8'h01);
    @(negedge clk); ctsN = 1'b1;
    repeat (DB + 2) @(posedge clk);
    @(negedge clk); chk("R8 irq not yet", {7'd0, irq}, 8'h00);
    @(posedge clk);
    @(negedge clk); chk("R8 irq one edge after status", {7'd0, irq}, 8'h01);

    // R4 read clears, irq drops one edge later
    busRead(2'd1, rd); chk("R4 R1 read data before clear", rd, 8'h11);
    chk("R8 irq still high at clear edge", {7'd0, irq}, 8'h01);
    @(posedge clk);
    @(negedge clk); chk("R4 irq drops after clear", {7'd0, irq}, 8'h00);

    // R5 collision: read ends on the qualifying edge
    @(negedge clk); ctsN = 1'b0;
    repeat (DB + 1) @(posedge clk);
    busRead(2'd1, rd); chk("R5 collision read data", rd, 8'h01);
    busRead(2'd2, rd); chk("R5 status survives", rd, 8'h01);
    busRead(2'd1, rd); chk("R5 flag survives", rd, 8'h10);

    // R6 enable off
    busWrite(2'd0, 8'h00);
    @(negedge clk); ctsN = 1'b1;
    repeat (2*DB + 6) @(negedge clk);
    busRead(2'd2, rd); chk("R6 status stays clear", rd, 8'h00);
    chk("R6 irq stays low", {7'd0, irq}, 8'h00);
    busRead(2'd1, rd); chk("R6 flag still set", rd, 8'h11);

    // R7 R8 sweep mask and generic inputs
    for (int m = 0; m < 8; m++) begin
      for (int g = 0; g < 4; g++) begin
        busWrite(2'd2, 8'(m));
        @(negedge clk); genStatus = NG'(g);
        repeat (2) @(negedge clk);
        chk("R8 mask sweep irq", {7'd0, irq},
            {7'd0, |((8'(g) << 1) & 8'(m))});
        busRead(2'd2, rd);
        chk("R7 status layout", rd, 8'(g) << 1);
      end
    end
    summary();
  end
endmodule